// File: doc/BRIEF.md
# Edge-Captured Event Flag Priority Encoder

This block watches a vector of already-synchronized event lines and turns transitions on them into sticky pending flags. Each line has its own polarity control that chooses whether a rising or a falling transition counts as an event. Firmware can raise events without any peripheral: a software trigger vector is ORed onto a fixed, parameter-selected subset of the lines, so toggling one of those bits creates the same transition as a hardware source would. A live status output always mirrors the merged level of every line. One position is reserved: its level still shows on the status output, but it can never flag.

A membership mask puts each event into a high-priority group or a low-priority group. Each group has its own encoder. It offers the pending flag with the lowest index in that group as a grant: a valid bit plus an index. The two groups grant independently, so one event from each group can be in service at the same time. Once a grant has been shown, it is locked and stays fixed until its consumer acknowledges that exact index. The acknowledge clears the flag. A fresh edge that lands in the same cycle as the acknowledge sets the flag again.

Top module: `evt_edge_prio_enc`

## Requirements
- R1: `live_lvl` equals `evt_in | (sw_trig & SW_MASK)` in the same cycle, the reserved position included. The default SW_MASK is 32'hC186_0C03, which maps bits 0, 1, 10, 11, 17, 18, 23, 24, 30 and 31.
- R2: With `polarity[i]`=0 a low-to-high transition of merged line i sets `pend_flags[i]`; with `polarity[i]`=1 only a high-to-low transition does. The flag is visible after the first rising clock edge that samples the new level.
- R3: A steady level never sets a flag. After reset the flags and both grants are clear, and inputs held at their idle level (all zero by default) raise nothing.
- R4: Position 25 (RSVD_IDX) never sets its pending flag, whatever its input does.
- R5: A transition on a `sw_trig` bit whose SW_MASK bit is 1 raises the matching event. A `sw_trig` bit whose mask bit is 0 (for example bit 12) changes neither `live_lvl` nor any flag.
- R6: `group_hi[i]`=1 puts event i in the high group and 0 puts it in the low group. When a group has no locked grant, its `*_valid`/`*_idx` show the lowest-index pending flag of that group in the same cycle.
- R7: The high and low grants are independent and can both be valid in the same cycle.
- R8: Once a grant has been presented for a cycle without an acknowledge, it keeps its index until it is acknowledged, even if a lower-index event of the same group becomes pending.
- R9: An acknowledge whose index equals the current grant index clears that flag at the clock edge, and the next winner appears in the following cycle. An acknowledge with any other index changes nothing.
- R10: If a qualifying edge on the granted event coincides with its acknowledge, the flag stays set and is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 32 | Synchronized event lines |
| sw_trig | input | 32 | Software trigger bits, merged through SW_MASK |
| polarity | input | 32 | Per-event edge select: 0 rising, 1 falling |
| group_hi | input | 32 | Per-event group: 1 high, 0 low |
| hi_ack | input | 1 | High-group acknowledge pulse |
| hi_ack_idx | input | 5 | Index being acknowledged in the high group |
| lo_ack | input | 1 | Low-group acknowledge pulse |
| lo_ack_idx | input | 5 | Index being acknowledged in the low group |
| live_lvl | output | 32 | Current merged level of every event line |
| pend_flags | output | 32 | Sticky pending flags |
| hi_valid | output | 1 | High-group grant valid |
| hi_idx | output | 5 | High-group granted index |
| lo_valid | output | 1 | Low-group grant valid |
| lo_idx | output | 5 | Low-group granted index |

## Verification
The assertions assume that `group_hi` is static whenever a flag is pending or a grant is held. If it changed at such a time, a locked index could move into the other group and the rule that each grant points at a pending member of its own group would no longer hold. The bench changes the mask only after it has acknowledged every outstanding grant. It changes polarity only while the affected line sits at a level that makes no new edge. Acknowledges are one-cycle pulses driven between clock edges, and the bench applies them only while the matching group shows a grant.

// File: rtl/evt_enc_pkg.sv
package evt_enc_pkg;
   localparam int GRP_LO  = 0;
   localparam int GRP_HI  = 1;
   localparam int NUM_GRP = 2;
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
   parameter int             N        = 32,
   parameter logic [N-1:0]   IDLE_LVL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] pol,
   output logic [N-1:0] edge_hit
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= lvl;
   end

   // pol=0 picks low-to-high, pol=1 picks high-to-low
   assign edge_hit = (~pol & ~prev_q & lvl) | (pol & prev_q & ~lvl);
endmodule

// File: rtl/evt_grp_arb.sv
module evt_grp_arb #(
   parameter int N        = 32,
   parameter bit PICK_LOW = 1'b1,
   localparam int IDX_W   = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     cand,
   input  logic             ack,
   input  logic [IDX_W-1:0] ack_idx,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx,
   output logic [N-1:0]     clr_vec
);
   logic             enc_hit;
   logic [IDX_W-1:0] enc_idx;
   logic             lock_v;
   logic [IDX_W-1:0] lock_idx;
   logic             ack_ok;

   generate
      if (PICK_LOW) begin : g_low_first
         always_comb begin
            enc_hit = 1'b0;
            enc_idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (cand[i]) begin
                  enc_hit = 1'b1;
                  enc_idx = IDX_W'(i);
               end
            end
         end
      end else begin : g_high_first
         always_comb begin
            enc_hit = 1'b0;
            enc_idx = '0;
            for (int i = 0; i < N; i++) begin
               if (cand[i]) begin
                  enc_hit = 1'b1;
                  enc_idx = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   assign gnt_valid = lock_v | enc_hit;
   assign gnt_idx   = lock_v ? lock_idx : enc_idx;
   assign ack_ok    = ack && gnt_valid && (ack_idx == gnt_idx);
   assign clr_vec   = ack_ok ? ({{(N-1){1'b0}}, 1'b1} << gnt_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_v   <= 1'b0;
         lock_idx <= '0;
      end else begin
         lock_v   <= gnt_valid & ~ack_ok;
         lock_idx <= gnt_idx;
      end
   end
endmodule

// File: rtl/evt_edge_prio_enc.sv
module evt_edge_prio_enc
   import evt_enc_pkg::*;
#(
   parameter int                 NUM_EVT  = 32,
   parameter int                 RSVD_IDX = 25,
   parameter logic [NUM_EVT-1:0] SW_MASK  = 32'hC186_0C03,
   parameter logic [NUM_EVT-1:0] IDLE_LVL = '0,
   parameter bit                 PICK_LOW = 1'b1,
   localparam int                IDX_W    = $clog2(NUM_EVT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic [NUM_EVT-1:0] sw_trig,
   input  logic [NUM_EVT-1:0] polarity,
   input  logic [NUM_EVT-1:0] group_hi,
   input  logic               hi_ack,
   input  logic [IDX_W-1:0]   hi_ack_idx,
   input  logic               lo_ack,
   input  logic [IDX_W-1:0]   lo_ack_idx,
   output logic [NUM_EVT-1:0] live_lvl,
   output logic [NUM_EVT-1:0] pend_flags,
   output logic               hi_valid,
   output logic [IDX_W-1:0]   hi_idx,
   output logic               lo_valid,
   output logic [IDX_W-1:0]   lo_idx
);
   localparam logic [NUM_EVT-1:0] RSVD_MASK = {{(NUM_EVT-1){1'b0}}, 1'b1} << RSVD_IDX;

   generate
      if (NUM_EVT < 2)
         $error("evt_edge_prio_enc: NUM_EVT must be at least 2");
      if (RSVD_IDX < 0 || RSVD_IDX >= NUM_EVT)
         $error("evt_edge_prio_enc: RSVD_IDX out of range");
   endgenerate

   logic [NUM_EVT-1:0] edge_hit;
   logic [NUM_EVT-1:0] flags_q;
   logic [NUM_EVT-1:0] grp_cand [NUM_GRP];
   logic [NUM_EVT-1:0] grp_clr  [NUM_GRP];
   logic               grp_ack  [NUM_GRP];
   logic [IDX_W-1:0]   grp_aidx [NUM_GRP];
   logic               grp_vld  [NUM_GRP];
   logic [IDX_W-1:0]   grp_idx  [NUM_GRP];

   assign live_lvl = evt_in | (sw_trig & SW_MASK);

   evt_edge_det #(.N(NUM_EVT), .IDLE_LVL(IDLE_LVL)) i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (live_lvl),
      .pol      (polarity),
      .edge_hit (edge_hit)
   );

   assign grp_ack[GRP_HI]  = hi_ack;
   assign grp_aidx[GRP_HI] = hi_ack_idx;
   assign grp_ack[GRP_LO]  = lo_ack;
   assign grp_aidx[GRP_LO] = lo_ack_idx;

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         if (g == GRP_HI) begin : g_member
            assign grp_cand[g] = flags_q & group_hi;
         end else begin : g_member
            assign grp_cand[g] = flags_q & ~group_hi;
         end

         evt_grp_arb #(.N(NUM_EVT), .PICK_LOW(PICK_LOW)) i_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .cand      (grp_cand[g]),
            .ack       (grp_ack[g]),
            .ack_idx   (grp_aidx[g]),
            .gnt_valid (grp_vld[g]),
            .gnt_idx   (grp_idx[g]),
            .clr_vec   (grp_clr[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= ((flags_q & ~(grp_clr[GRP_HI] | grp_clr[GRP_LO])) | edge_hit)
                             & ~RSVD_MASK;
   end

   assign pend_flags = flags_q;
   assign hi_valid   = grp_vld[GRP_HI];
   assign hi_idx     = grp_idx[GRP_HI];
   assign lo_valid   = grp_vld[GRP_LO];
   assign lo_idx     = grp_idx[GRP_LO];
endmodule

// File: rtl/evt_edge_prio_enc_chk.sv
module evt_edge_prio_enc_chk #(
   parameter int  NUM_EVT  = 32,
   parameter int  RSVD_IDX = 25,
   localparam int IDX_W    = $clog2(NUM_EVT)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] evt_in,
   input logic [NUM_EVT-1:0] sw_trig,
   input logic [NUM_EVT-1:0] polarity,
   input logic [NUM_EVT-1:0] group_hi,
   input logic               hi_ack,
   input logic [IDX_W-1:0]   hi_ack_idx,
   input logic               lo_ack,
   input logic [IDX_W-1:0]   lo_ack_idx,
   input logic [NUM_EVT-1:0] live_lvl,
   input logic [NUM_EVT-1:0] pend_flags,
   input logic               hi_valid,
   input logic [IDX_W-1:0]   hi_idx,
   input logic               lo_valid,
   input logic [IDX_W-1:0]   lo_idx
);
   assert_rsvd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_flags[RSVD_IDX]);

   assert_hi_member_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_valid |-> (pend_flags[hi_idx] && group_hi[hi_idx]));

   assert_lo_member_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_valid |-> (pend_flags[lo_idx] && !group_hi[lo_idx]));

   assert_dual_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_valid && lo_valid) |-> (hi_idx != lo_idx));

   assert_hi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_valid && !(hi_ack && hi_ack_idx == hi_idx)) |=> (hi_valid && hi_idx == $past(hi_idx)));

   assert_lo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_valid && !(lo_ack && lo_ack_idx == lo_idx)) |=> (lo_valid && lo_idx == $past(lo_idx)));

   assert_lo_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_valid && lo_ack && lo_ack_idx == lo_idx && live_lvl[lo_idx] == $past(live_lvl[lo_idx]))
      |=> !pend_flags[$past(lo_idx)]);
endmodule

bind evt_edge_prio_enc evt_edge_prio_enc_chk #(.NUM_EVT(NUM_EVT), .RSVD_IDX(RSVD_IDX)) i_chk (.*);

// File: tb/test_evt_edge_prio_enc.sv
`timescale 1ns/1ps
module test_evt_edge_prio_enc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_in = '0, sw_trig = '0, polarity = '0, group_hi = '0;
   logic        hi_ack = 1'b0, lo_ack = 1'b0;
   logic [4:0]  hi_ack_idx = '0, lo_ack_idx = '0;
   logic [31:0] live_lvl, pend_flags;
   logic        hi_valid, lo_valid;
   logic [4:0]  hi_idx, lo_idx;
   int          checks = 0, errors = 0;

   always #10 clk = ~clk;

   evt_edge_prio_enc i_evt_edge_prio_enc (.*);

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_lo(input bit v, input int idx, input string tag);
      chk(lo_valid == v && (!v || lo_idx == 5'(idx)), tag, {lo_valid, 26'd0, lo_idx}, {v, 26'd0, 5'(idx)});
   endtask

   task automatic chk_hi(input bit v, input int idx, input string tag);
      chk(hi_valid == v && (!v || hi_idx == 5'(idx)), tag, {hi_valid, 26'd0, hi_idx}, {v, 26'd0, 5'(idx)});
   endtask

   task automatic ack_lo(input int idx);
      lo_ack = 1'b1; lo_ack_idx = 5'(idx);
      step();
      lo_ack = 1'b0;
   endtask

   task automatic clear_all();
      for (int k = 0; k < 40; k++) begin
         if (!hi_valid && !lo_valid) break;
         hi_ack = hi_valid; hi_ack_idx = hi_idx;
         lo_ack = lo_valid; lo_ack_idx = lo_idx;
         step();
         hi_ack = 1'b0; lo_ack = 1'b0;
      end
   endtask

   task automatic t_reset();
      chk(pend_flags == 0, "R3 reset flags", pend_flags, 0);
      chk_hi(0, 0, "R3 reset hi grant");
      chk_lo(0, 0, "R3 reset lo grant");
      step(); step();
      chk(pend_flags == 0, "R3 idle after reset", pend_flags, 0);
   endtask

   task automatic t_live_merge();
      evt_in = 32'h0000_00F0; sw_trig = 32'h0000_1403;
      #1;
      chk(live_lvl == 32'h0000_04F3, "R1 R5 live merge", live_lvl, 32'h0000_04F3);
      step();
      chk(pend_flags == 32'h0000_04F3, "R2 R5 merged rising flags", pend_flags, 32'h0000_04F3);
      evt_in = '0; sw_trig = '0;
      step();
      clear_all();
      chk(pend_flags == 0, "R9 drained", pend_flags, 0);
   endtask

   task automatic t_rising();
      evt_in[4] = 1'b1;
      step();
      chk_lo(1, 4, "R2 rising grant lo");
      chk_hi(0, 0, "R6 nothing in hi");
      step(); step();
      ack_lo(4);
      chk(pend_flags == 0, "R9 ack clears", pend_flags, 0);
      chk_lo(0, 0, "R9 no grant after ack");
      step(); step();
      chk(pend_flags == 0, "R3 steady high no refire", pend_flags, 0);
      evt_in[4] = 1'b0;
      step();
      chk(pend_flags == 0, "R2 falling ignored at pol0", pend_flags, 0);
   endtask

   task automatic t_falling();
      polarity[6] = 1'b1;
      evt_in[6] = 1'b1;
      step();
      chk(pend_flags == 0, "R2 rising ignored at pol1", pend_flags, 0);
      evt_in[6] = 1'b0;
      step();
      chk_lo(1, 6, "R2 falling grant at pol1");
      ack_lo(6);
      polarity[6] = 1'b0;
      chk(pend_flags == 0, "R9 falling ack", pend_flags, 0);
   endtask

   task automatic t_reserved();
      evt_in[25] = 1'b1;
      #1;
      chk(live_lvl[25] == 1'b1, "R1 reserved level shown", live_lvl, 32'h0200_0000);
      step();
      chk(pend_flags == 0, "R4 reserved rise", pend_flags, 0);
      evt_in[25] = 1'b0;
      step();
      chk(pend_flags == 0 && !lo_valid, "R4 reserved fall", pend_flags, 0);
   endtask

   task automatic t_sw();
      sw_trig[10] = 1'b1;
      step();
      sw_trig[10] = 1'b0;
      chk_lo(1, 10, "R5 mapped sw event");
      ack_lo(10);
      sw_trig[12] = 1'b1;
      #1;
      chk(live_lvl == 0, "R5 unmapped sw level", live_lvl, 0);
      step();
      chk(pend_flags == 0, "R5 unmapped sw no flag", pend_flags, 0);
      sw_trig[12] = 1'b0;
      step();
   endtask

   task automatic t_groups();
      group_hi = (32'd1 << 3) | (32'd1 << 20);
      evt_in = (32'd1 << 3) | (32'd1 << 20) | (32'd1 << 7) | (32'd1 << 15);
      step();
      evt_in = '0;
      chk_hi(1, 3, "R6 R7 hi lowest");
      chk_lo(1, 7, "R6 R7 lo lowest");
      hi_ack = 1'b1; hi_ack_idx = 5'd3;
      lo_ack = 1'b1; lo_ack_idx = 5'd7;
      step();
      hi_ack = 1'b0; lo_ack = 1'b0;
      chk_hi(1, 20, "R9 hi next winner");
      chk_lo(1, 15, "R9 lo next winner");
      clear_all();
      chk(pend_flags == 0 && !hi_valid, "R9 groups drained", pend_flags, 0);
      group_hi = '0;
   endtask

   task automatic t_hold();
      evt_in[9] = 1'b1;
      step();
      evt_in[9] = 1'b0;
      chk_lo(1, 9, "R6 grant 9");
      evt_in[2] = 1'b1;
      step();
      evt_in[2] = 1'b0;
      chk_lo(1, 9, "R8 held despite lower index");
      chk(pend_flags == 32'h0000_0204, "R8 both pending", pend_flags, 32'h0000_0204);
      step();
      chk_lo(1, 9, "R8 still held");
      ack_lo(9);
      chk_lo(1, 2, "R9 lower index after ack");
      ack_lo(7);
      chk_lo(1, 2, "R9 mismatched ack ignored");
      chk(pend_flags == 32'h0000_0004, "R9 mismatched ack keeps flag", pend_flags, 32'h0000_0004);
      ack_lo(2);
   endtask

   task automatic t_ack_edge();
      evt_in[5] = 1'b1;
      step();
      evt_in[5] = 1'b0;
      step();
      chk_lo(1, 5, "R10 setup grant 5");
      evt_in[5] = 1'b1;
      ack_lo(5);
      chk(pend_flags[5] == 1'b1, "R10 edge with ack re-sets", pend_flags, 32'h0000_0020);
      chk_lo(1, 5, "R10 re-granted");
      evt_in[5] = 1'b0;
      ack_lo(5);
      chk(pend_flags == 0, "R10 final clear", pend_flags, 0);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_live_merge();
      t_rising();
      t_falling();
      t_reserved();
      t_sw();
      t_groups();
      t_hold();
      t_ack_edge();
      step();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule